// File: doc/BRIEF.md
# Doubleword load/store address unit

This unit prepares a 64-bit memory access for a register pair. From a base register, a register offset and an 8-bit immediate supplied as two nibbles, it forms the memory address and the new base value. A 5-bit mode field chooses between these options:

- pre-index or post-index addressing;
- adding or subtracting the offset;
- a register offset or an immediate offset;
- base writeback on or off.

On a store, the unit packs two 32-bit source words into one 64-bit write word. On a load, it splits the 64-bit word returned by memory into an even and an odd destination word.

A request strobe starts one operation. Every result appears, registered, one cycle later with a one-cycle valid pulse. Memory is expected to answer a load in that same cycle, and the split load words are driven straight from that answer. A mode code with its lowest bit set does not belong to this unit. It is reported as illegal and produces neither a memory access nor a base update.

Top module: `ldst_pair_agu`

## Requirements
- R1: A request whose mode bit 0 is 1 gives, one cycle later, `vld`=1 and `illegal`=1 with `mem_req`=0, `wb_en`=0 and `ld_we`=0.
- R2: With mode bit 4 (pre-index) at 0, `mem_addr` equals the unmodified base. `wb_en` is 1 with `wb_data` = base plus or minus the offset, whatever mode bit 1 is (subject to R9).
- R3: With mode bit 4 at 1, `mem_addr` is base plus or minus the offset. `wb_en` is 1 only when mode bit 1 (writeback) is 1, and then `wb_data` equals `mem_addr`.
- R4: With mode bit 2 (immediate) at 0, the offset is `ofs_reg`. Mode bit 3 at 0 subtracts it and at 1 adds it.
- R5: With mode bit 2 at 1, the offset is {`imm_hi`,`imm_lo`} zero-extended to 32 bits. It is always added, whatever mode bit 3 is.
- R6: On a load (`is_load`=1), `ld_we`=1 while `vld` is 1, `ld_even` = `mem_rdata`[31:0] and `ld_odd` = `mem_rdata`[63:32].
- R7: On a store, `mem_we`=1 and `mem_wdata` = {`st_odd`,`st_even`}. On a load, `mem_we`=0.
- R8: `vld` and `mem_req` pulse high exactly in the cycle after a cycle with `req`=1, and are 0 otherwise, including after reset.
- R9: On a load whose even index `pair_idx` or odd index `pair_idx`+1 (modulo 16) equals `base_idx`, `wb_en` is 0, so the loaded data wins.
- R10: All address and writeback arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Operation strobe |
| is_load | input | 1 | 1 = load, 0 = store |
| mode | input | 5 | Addressing mode {P,U,I,W,L} |
| base | input | 32 | Base register value |
| ofs_reg | input | 32 | Register offset |
| imm_hi | input | 4 | Immediate high nibble |
| imm_lo | input | 4 | Immediate low nibble |
| base_idx | input | 4 | Base register index |
| pair_idx | input | 4 | Even register index of the pair |
| st_even | input | 32 | Store word for bits 31:0 |
| st_odd | input | 32 | Store word for bits 63:32 |
| mem_rdata | input | 64 | Memory read data (same cycle as mem_req) |
| vld | output | 1 | Result valid pulse |
| illegal | output | 1 | Mode code not handled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 64 | Memory write word |
| wb_en | output | 1 | Base writeback enable |
| wb_data | output | 32 | New base value |
| ld_we | output | 1 | Destination pair write enable |
| ld_even | output | 32 | Even destination word |
| ld_odd | output | 32 | Odd destination word |

## Verification
Random operations run over all 32 mode codes with random operands. Comparing the address against the writeback value separates pre-index from post-index. Comparing add against subtract under both offset sources exposes any use of the add/subtract bit with the immediate. Directed cases cover:

- bases near zero and near the top of the address range, to show wrap-around;
- a load whose even or odd destination equals the base index, including pair index 15 wrapping to 0, to isolate the priority of the load data;
- idle cycles between requests, to show that no stray valid pulse appears.

// File: rtl/ldst_pair_agu.sv
module ldst_pair_agu #(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            is_load,
  input  logic [4:0]      mode,
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   ofs_reg,
  input  logic [3:0]      imm_hi,
  input  logic [3:0]      imm_lo,
  input  logic [RIW-1:0]  base_idx,
  input  logic [RIW-1:0]  pair_idx,
  input  logic [DW-1:0]   st_even,
  input  logic [DW-1:0]   st_odd,
  input  logic [2*DW-1:0] mem_rdata,
  output logic            vld,
  output logic            illegal,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [2*DW-1:0] mem_wdata,
  output logic            wb_en,
  output logic [DW-1:0]   wb_data,
  output logic            ld_we,
  output logic [DW-1:0]   ld_even,
  output logic [DW-1:0]   ld_odd
);
  localparam int IMW = 8;

  logic pre, up, use_imm, wr_back, bad;
  assign {pre, up, use_imm, wr_back, bad} = mode;

  logic [DW-1:0]  offset, moved, addr_n;
  logic [RIW-1:0] odd_idx;
  logic           hit, wb_n;

  assign offset  = use_imm ? {{(DW-IMW){1'b0}}, imm_hi, imm_lo} : ofs_reg;
  assign moved   = (use_imm || up) ? base + offset : base - offset;
  assign addr_n  = pre ? moved : base;
  assign odd_idx = pair_idx + RIW'(1);
  assign hit     = is_load && (base_idx == pair_idx || base_idx == odd_idx);
  assign wb_n    = !bad && (!pre || wr_back) && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      illegal   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      wb_en     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_data   <= '0;
    end else begin
      vld     <= req;
      illegal <= req && bad;
      mem_req <= req && !bad;
      mem_we  <= req && !bad && !is_load;
      wb_en   <= req && wb_n;
      if (req) begin
        mem_addr  <= addr_n;
        mem_wdata <= {st_odd, st_even};
        wb_data   <= moved;
      end
    end
  end

  assign ld_we   = mem_req && !mem_we;
  assign ld_even = mem_rdata[DW-1:0];
  assign ld_odd  = mem_rdata[2*DW-1:DW];

  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && illegal) |-> (!mem_req && !wb_en && !ld_we));
  a_r8_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);
  a_r8_vld_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(req));
  a_r8_req_within_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || wb_en || illegal) |-> vld);
  a_r3_pre_wb_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pre && !bad) |=> (!wb_en || wb_data == mem_addr));
  a_r2_post_addr_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !pre && !bad) |=> (mem_addr == $past(base)));
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit) |=> !wb_en);
  a_r7_we_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && !ld_we));
endmodule

// File: tb/sim_ldst_pair_agu.sv
module sim_ldst_pair_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req = 0, is_load = 0;
  logic [4:0]  mode = 0;
  logic [31:0] base = 0, ofs_reg = 0, st_even = 0, st_odd = 0;
  logic [3:0]  imm_hi = 0, imm_lo = 0, base_idx = 0, pair_idx = 0;
  logic [63:0] mem_rdata = 0;
  logic        vld, illegal, mem_req, mem_we, wb_en, ld_we;
  logic [31:0] mem_addr, wb_data, ld_even, ld_odd;
  logic [63:0] mem_wdata;

  ldst_pair_agu u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_moved(input logic [4:0] m, input logic [31:0] b,
                                          input logic [31:0] r, input logic [3:0] h, input logic [3:0] l);
    logic [31:0] o;
    o = m[2] ? {24'd0, h, l} : r;
    return (m[2] || m[3]) ? b + o : b - o;
  endfunction

  task automatic run_op(input bit ld, input logic [4:0] m, input logic [31:0] b, input logic [31:0] r,
                        input logic [3:0] h, input logic [3:0] l, input logic [3:0] bi, input logic [3:0] pi);
    logic [31:0] mv, ea;
    bit bad, hit, ewb;
    @(negedge clk);
    req = 1; is_load = ld; mode = m; base = b; ofs_reg = r; imm_hi = h; imm_lo = l;
    base_idx = bi; pair_idx = pi;
    st_even = $urandom; st_odd = $urandom; mem_rdata = {$urandom, $urandom};
    mv  = e_moved(m, b, r, h, l);
    ea  = m[4] ? mv : b;
    bad = m[0];
    hit = ld && (bi == pi || bi == 4'(pi + 1));
    ewb = !bad && (!m[4] || m[1]) && !hit;
    @(negedge clk);
    req = 0;
    chk(vld == 1, "R8 vld", 64'(vld), 1);
    chk(illegal == bad, "R1 illegal", 64'(illegal), 64'(bad));
    chk(mem_req == !bad, "R1 mem_req", 64'(mem_req), 64'(!bad));
    chk(wb_en == ewb, "R2/R3/R9 wb_en", 64'(wb_en), 64'(ewb));
    if (!bad) begin
      chk(mem_addr == ea, m[4] ? "R3 pre addr" : "R2 post addr", 64'(mem_addr), 64'(ea));
      if (ewb) chk(wb_data == mv, m[2] ? "R5 wb imm" : "R4 wb reg", 64'(wb_data), 64'(mv));
      chk(mem_we == !ld, "R7 mem_we", 64'(mem_we), 64'(!ld));
      chk(ld_we == ld, "R6 ld_we", 64'(ld_we), 64'(ld));
      if (ld) begin
        chk(ld_even == mem_rdata[31:0], "R6 even", 64'(ld_even), 64'(mem_rdata[31:0]));
        chk(ld_odd == mem_rdata[63:32], "R6 odd", 64'(ld_odd), 64'(mem_rdata[63:32]));
      end else
        chk(mem_wdata == {st_odd, st_even}, "R7 pack", mem_wdata, {st_odd, st_even});
    end else
      chk(ld_we == 0, "R1 ld_we", 64'(ld_we), 0);
    @(negedge clk);
    chk(vld == 0 && mem_req == 0 && wb_en == 0, "R8 idle", 64'({vld, mem_req, wb_en}), 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(vld == 0 && mem_req == 0 && wb_en == 0 && mem_addr == 0, "R8 reset", 64'({vld, mem_req, wb_en}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(vld == 0, "R8 no req", 64'(vld), 0);
    // R1 illegal codes
    run_op(1, 5'h01, 32'h100, 32'h4, 4'h0, 4'h8, 4'd1, 4'd2);
    run_op(0, 5'h1F, 32'h100, 32'h4, 4'h0, 4'h8, 4'd1, 4'd2);
    // R4 register subtract/add, pre and post
    run_op(0, 5'h10, 32'h1000, 32'h10, 4'h0, 4'h0, 4'd1, 4'd4);
    run_op(0, 5'h18, 32'h1000, 32'h10, 4'h0, 4'h0, 4'd1, 4'd4);
    run_op(1, 5'h00, 32'h1000, 32'h10, 4'h0, 4'h0, 4'd1, 4'd4);
    // R5 immediate with U=0 still adds
    run_op(1, 5'h14, 32'h2000, 32'hFFFF, 4'hA, 4'h5, 4'd1, 4'd4);
    run_op(0, 5'h16, 32'h2000, 32'hFFFF, 4'hF, 4'hF, 4'd1, 4'd4);
    run_op(0, 5'h04, 32'h2000, 32'h0, 4'h1, 4'h2, 4'd1, 4'd4);
    // R10 wrap
    run_op(0, 5'h12, 32'h4, 32'h10, 4'h0, 4'h0, 4'd1, 4'd4);
    run_op(1, 5'h1E, 32'hFFFF_FFF0, 32'h0, 4'h2, 4'h0, 4'd1, 4'd4);
    // R9 conflicts: even, odd, odd index wrap 15 -> 0
    run_op(1, 5'h1A, 32'h3000, 32'h8, 4'h0, 4'h0, 4'd6, 4'd6);
    run_op(1, 5'h08, 32'h3000, 32'h8, 4'h0, 4'h0, 4'd7, 4'd6);
    run_op(1, 5'h0C, 32'h3000, 32'h8, 4'h0, 4'h3, 4'd0, 4'd15);
    run_op(0, 5'h1A, 32'h3000, 32'h8, 4'h0, 4'h0, 4'd6, 4'd6);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      b = ($urandom % 4 == 0) ? 32'hFFFF_FF00 | 32'($urandom % 256) : $urandom;
      run_op(1'($urandom), 5'($urandom), b, $urandom, 4'($urandom), 4'($urandom),
             4'($urandom), 4'($urandom) & 4'hE);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule